// File: doc/BRIEF.md
# Serial Timebase Divider Chain

This block derives every timing reference a serial protocol engine needs from a single peripheral clock. It never produces a derived clock. Each reference is a one-cycle enable strobe in the peripheral clock domain. A protocol-rate tick runs at either the full or the half peripheral rate. That tick feeds a programmable integer divider. A four-way selector then chooses the sample tick from:

- the divided tick,
- the protocol tick,
- the rising edges of an external serial clock, or
- every peripheral cycle.

The sample tick passes through two dividers in series: a pre-divider followed by a denominator divider. Beside the chain sits a 10-bit measurement counter. When enabled, it advances on protocol ticks or on divided ticks.

All settings arrive as one configuration word, captured when the write strobe is high. That write cycle clears:

- every divider counter,
- the half-rate phase, and
- the measurement counter.

No strobe fires during the write cycle, so the first pulse after a change always follows a full new period.

Top module: `serial_timebase`

## Requirements
- R1: After reset the configuration is all zero: the divided, sample, pre-divider and denominator strobes pulse on every cycle, and the measurement count is 0.
- R2: Configuration bit 0 set selects the half-rate protocol tick. It pulses on every second cycle, with the first pulse in the second cycle after the write. Bit 0 clear gives a protocol tick on every cycle.
- R3: The divided strobe pulses once per (D+1) protocol ticks, where D is configuration bits [10:1]. The pulse coincides with the (D+1)-th tick counted after the write.
- R4: Configuration bits [12:11] choose the sample tick: 0 is the divided strobe, 1 is the protocol tick, 2 is the serial-clock rising edge, 3 is every cycle.
- R5: `sclk_i` passes through a two-flop synchronizer. Each rising edge gives exactly one sample tick, in the cycle that follows the second clock edge after the rise.
- R6: The pre-divider strobe pulses once per (P+1) sample ticks, where P is configuration bits [14:13].
- R7: The denominator strobe pulses once per (Q+1) pre-divider strobes, where Q is configuration bits [19:15].
- R8: Configuration bit 20 enables the measurement counter, and bit 21 picks its tick: 0 is the protocol tick, 1 is the divided strobe. The counter wraps from 1023 to 0 and holds while disabled.
- R9: In the cycle the write strobe is high, no output strobe fires. Afterwards every divider counter, the half-rate phase and the measurement count restart from zero.
- R10: A divide value of 0 in any stage passes each input tick straight through, and no stage pulses without an input tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_i | input | 22 | Configuration word (fields per R2 to R8) |
| sclk_i | input | 1 | External serial clock, asynchronous |
| div_tick_o | output | 1 | Divided-clock strobe |
| samp_tick_o | output | 1 | Sample-clock strobe |
| pre_tick_o | output | 1 | Pre-divider strobe |
| den_tick_o | output | 1 | Denominator strobe |
| meas_cnt_o | output | 10 | Measurement counter value |

## Verification
The assertions check these properties on every cycle:

- the write cycle stays quiet and clears the measurement count;
- the half-rate protocol tick never fires on two cycles in a row;
- a synchronized serial edge never lasts more than one cycle;
- no stage counter exceeds its ratio, and no stage pulses without an input tick;
- a disabled measurement counter holds.

The exact pulse spacing of each ratio, the source chosen for each select value, the synchronizer latency, and the counter wrap are shown only by the bench. It compares every output against a behavioural model on every cycle and counts pulses over fixed windows.

// File: rtl/serial_timebase_pkg.sv
package serial_timebase_pkg;
  parameter int unsigned DIV_W  = 10;
  parameter int unsigned PRE_W  = 2;
  parameter int unsigned DEN_W  = 5;
  parameter int unsigned MEAS_W = 10;

  typedef enum logic [1:0] {
    SAMP_DIV  = 2'd0,
    SAMP_PROT = 2'd1,
    SAMP_SCLK = 2'd2,
    SAMP_REF  = 2'd3
  } samp_src_e;

  typedef struct packed {
    logic             meas_src;
    logic             meas_en;
    logic [DEN_W-1:0] den_ratio;
    logic [PRE_W-1:0] pre_ratio;
    samp_src_e        samp_sel;
    logic [DIV_W-1:0] div_ratio;
    logic             prot_half;
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);
endpackage

// File: rtl/tb_sclk_sync.sv
module tb_sclk_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic rise_o
);
  logic [2:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], sclk_i};
  end

  assign rise_o = sync_q[1] & ~sync_q[2];

  assert_single_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tick_div_stage.sv
module tick_div_stage #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] ratio_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap   = (cnt_q == ratio_i);
  assign tick_o = tick_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  assert_cnt_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= ratio_i);
  assert_no_pulse_without_input_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> tick_i);
endmodule

// File: rtl/meas_counter.sv
module meas_counter #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (en_i && tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_hold_when_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/serial_timebase.sv
module serial_timebase
  import serial_timebase_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              sclk_i,
  output logic              div_tick_o,
  output logic              samp_tick_o,
  output logic              pre_tick_o,
  output logic              den_tick_o,
  output logic [MEAS_W-1:0] meas_cnt_o
);
  cfg_t cfg_q;
  logic half_q;
  logic run;
  logic prot_tick, div_tick, sclk_rise, samp_tick, pre_tick, den_tick, meas_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_t'(cfg_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       half_q <= 1'b0;
    else if (cfg_we_i) half_q <= 1'b0;
    else               half_q <= ~half_q;
  end

  // all strobes are suppressed in the write cycle
  assign run       = ~cfg_we_i;
  assign prot_tick = run & (cfg_q.prot_half ? half_q : 1'b1);

  tb_sclk_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .rise_o (sclk_rise)
  );

  tick_div_stage #(.W(DIV_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cfg_we_i),
    .tick_i  (prot_tick),
    .ratio_i (cfg_q.div_ratio),
    .tick_o  (div_tick)
  );

  always_comb begin
    unique case (cfg_q.samp_sel)
      SAMP_DIV:  samp_tick = div_tick;
      SAMP_PROT: samp_tick = prot_tick;
      SAMP_SCLK: samp_tick = run & sclk_rise;
      default:   samp_tick = run;
    endcase
  end

  tick_div_stage #(.W(PRE_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cfg_we_i),
    .tick_i  (samp_tick),
    .ratio_i (cfg_q.pre_ratio),
    .tick_o  (pre_tick)
  );

  tick_div_stage #(.W(DEN_W)) u_den (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cfg_we_i),
    .tick_i  (pre_tick),
    .ratio_i (cfg_q.den_ratio),
    .tick_o  (den_tick)
  );

  assign meas_tick = cfg_q.meas_src ? div_tick : prot_tick;

  meas_counter #(.W(MEAS_W)) u_meas (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cfg_we_i),
    .en_i   (cfg_q.meas_en),
    .tick_i (meas_tick),
    .cnt_o  (meas_cnt_o)
  );

  assign div_tick_o  = div_tick;
  assign samp_tick_o = samp_tick;
  assign pre_tick_o  = pre_tick;
  assign den_tick_o  = den_tick;

  assert_quiet_on_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |-> !(div_tick_o || samp_tick_o || pre_tick_o || den_tick_o));
  assert_meas_cleared_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (meas_cnt_o == '0));
  assert_half_rate_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.prot_half && prot_tick) |=> !prot_tick);
endmodule

// File: tb/serial_timebase_tb.sv
module serial_timebase_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [21:0] cfg_i = '0;
  logic        sclk_i = 1'b0;
  logic        div_tick_o, samp_tick_o, pre_tick_o, den_tick_o;
  logic [9:0]  meas_cnt_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int n_samp = 0, n_pre = 0, n_den = 0, n_div = 0;

  always #5 clk_i = ~clk_i;

  serial_timebase u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_i(cfg_i),
    .sclk_i(sclk_i), .div_tick_o(div_tick_o), .samp_tick_o(samp_tick_o),
    .pre_tick_o(pre_tick_o), .den_tick_o(den_tick_o), .meas_cnt_o(meas_cnt_o)
  );

  // behavioural reference model state
  int m_half, m_divr, m_sel, m_prer, m_denr, m_men, m_msrc;
  int m_div, m_pre, m_den, m_meas;
  int m_s1, m_s2, m_s3;
  bit e_prot, e_div, e_samp, e_pre, e_den;

  function automatic void model_eval();
    bit go = !cfg_we_i;
    bit ph;
    ph     = (m_half != 0) ? (m_s_phase != 0) : 1'b1;
    e_prot = go && ph;
    e_div  = e_prot && (m_div == m_divr);
    case (m_sel)
      0: e_samp = e_div;
      1: e_samp = e_prot;
      2: e_samp = go && (m_s2 == 1) && (m_s3 == 0);
      default: e_samp = go;
    endcase
    e_pre = e_samp && (m_pre == m_prer);
    e_den = e_pre && (m_den == m_denr);
  endfunction

  int m_s_phase;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_half = 0; m_divr = 0; m_sel = 0; m_prer = 0; m_denr = 0; m_men = 0; m_msrc = 0;
      m_div = 0; m_pre = 0; m_den = 0; m_meas = 0; m_s_phase = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      model_eval();
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = sclk_i;
      if (cfg_we_i) begin
        m_half = cfg_i[0];        m_divr = cfg_i[10:1]; m_sel = cfg_i[12:11];
        m_prer = cfg_i[14:13];    m_denr = cfg_i[19:15];
        m_men  = cfg_i[20];       m_msrc = cfg_i[21];
        m_div = 0; m_pre = 0; m_den = 0; m_meas = 0; m_s_phase = 0;
      end else begin
        m_s_phase = 1 - m_s_phase;
        if (e_prot) m_div = e_div ? 0 : m_div + 1;
        if (e_samp) m_pre = e_pre ? 0 : m_pre + 1;
        if (e_pre)  m_den = e_den ? 0 : m_den + 1;
        if (m_men != 0 && ((m_msrc != 0) ? e_div : e_prot)) m_meas = (m_meas + 1) % 1024;
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      model_eval();
      chk(div_tick_o == e_div,   "R3 div strobe",  div_tick_o,  e_div);
      chk(samp_tick_o == e_samp, "R4 samp strobe", samp_tick_o, e_samp);
      chk(pre_tick_o == e_pre,   "R6 pre strobe",  pre_tick_o,  e_pre);
      chk(den_tick_o == e_den,   "R7 den strobe",  den_tick_o,  e_den);
      chk(meas_cnt_o == m_meas,  "R8 meas count",  meas_cnt_o,  m_meas);
      if (cfg_we_i)
        chk({div_tick_o, samp_tick_o, pre_tick_o, den_tick_o} == 4'b0, "R9 write quiet",
            {div_tick_o, samp_tick_o, pre_tick_o, den_tick_o}, 0);
      n_div  += div_tick_o;
      n_samp += samp_tick_o;
      n_pre  += pre_tick_o;
      n_den  += den_tick_o;
    end
  end

  function automatic logic [21:0] mk(int msrc, int men, int den, int pre, int sel, int dv, int half);
    return {msrc[0], men[0], den[4:0], pre[1:0], sel[1:0], dv[9:0], half[0]};
  endfunction

  task automatic wr(logic [21:0] w);
    @(posedge clk_i); #1; cfg_we_i = 1'b1; cfg_i = w;
    @(posedge clk_i); #1; cfg_we_i = 1'b0;
    n_div = 0; n_samp = 0; n_pre = 0; n_den = 0;
  endtask

  task automatic run(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk({div_tick_o, samp_tick_o, pre_tick_o, den_tick_o} == 4'b1111, "R1 reset strobes",
        {div_tick_o, samp_tick_o, pre_tick_o, den_tick_o}, 15);
    chk(meas_cnt_o == 0, "R1 reset meas", meas_cnt_o, 0);

    // R2 half-rate protocol tick on the sample output
    wr(mk(0, 0, 0, 0, 1, 0, 1));
    run(20);
    chk(n_samp == 10, "R2 half-rate count", n_samp, 10);

    // R3 divide by 5 from full-rate protocol tick
    wr(mk(0, 0, 0, 0, 0, 4, 0));
    run(25);
    chk(n_div == 5, "R3 divide-by-5 count", n_div, 5);

    // R6 R7 pre by 4, den by 3 on every-cycle sample
    wr(mk(0, 0, 2, 3, 3, 0, 0));
    run(48);
    chk(n_pre == 12, "R6 pre count", n_pre, 12);
    chk(n_den == 4, "R7 den count", n_den, 4);

    // R10 zero ratios pass straight through
    wr(mk(0, 0, 0, 0, 3, 0, 0));
    run(17);
    chk(n_den == 17, "R10 pass-through count", n_den, 17);

    // R5 serial clock edges
    wr(mk(0, 0, 0, 0, 2, 0, 0));
    for (int i = 0; i < 4; i++) begin
      sclk_i = 1'b1; run(3);
      sclk_i = 1'b0; run(3);
    end
    run(4);
    chk(n_samp == 4, "R5 sclk edge count", n_samp, 4);

    // R4 divided source with half rate, divide by 3
    wr(mk(0, 0, 0, 0, 0, 2, 1));
    run(30);
    chk(n_samp == 5, "R4 divided source count", n_samp, 5);

    // R8 measurement on divided ticks, then disabled, then wrap on protocol ticks
    wr(mk(1, 1, 0, 0, 0, 3, 0));
    run(40);
    chk(meas_cnt_o == 10, "R8 meas div source", meas_cnt_o, 10);
    wr(mk(0, 0, 0, 0, 1, 0, 0));
    run(30);
    chk(meas_cnt_o == 0, "R8 meas disabled", meas_cnt_o, 0);
    wr(mk(0, 1, 0, 0, 1, 0, 0));
    run(1030);
    chk(meas_cnt_o == 6, "R8 meas wrap", meas_cnt_o, 6);

    // R9 reconfigure mid-period: next pulse follows full new period
    wr(mk(0, 0, 0, 0, 0, 9, 0));
    run(7);
    wr(mk(0, 0, 0, 0, 0, 2, 0));
    run(2);
    chk(n_div == 0, "R9 no early pulse", n_div, 0);
    run(1);
    chk(n_div == 1, "R9 first full period", n_div, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule